// File: doc/BRIEF.md
# Edge-Detect Interrupt I/O Port

This block is an eight-pin general-purpose port in which every pin can act either as plain discrete I/O or as a watched input. A watched input raises a prioritized, vectored interrupt when it sees a chosen transition. Software reaches the block through a small register bus with a write strobe, an address and one 16-bit data word. Reads are combinational from the current address.

An output latch and a direction mask drive the pins. Each pin has a 2-bit transition selector. When a selected transition occurs, the pin's sticky flag is set. All pins share one priority value and one vector value.

While any watched pin has its flag set and the priority value is non-zero, the block requests an interrupt at that priority. During an acknowledge cycle at the matching priority, the block supplies the vector. Arbitration against other sources happens outside the block. The block only reports that it sits at the bottom of that order.

Top module: `edgeirq_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, `irq_req` is 0 and `irq_level` is 0.
- R2: A write to address 0 loads the output latch, and `pin_out` shows the latch on the next cycle. A write to address 1 loads the direction mask. `pin_oe` equals that mask, where 1 means output.
- R3: Address 0 is read bit by bit. A bit whose direction is 0 and whose selector is 00 returns the synchronized pin value. Every other bit returns the latch bit.
- R4: Address 2 holds the selectors, with bits [2i+1:2i] belonging to pin i. The codes are 00 off, 01 rising, 10 falling and 11 both. A selected transition sets flag i at the third rising clock edge after the pin changes, and not before.
- R5: Address 3 reads the flags. Writing 1 to a bit clears that flag. If a new transition arrives in the same cycle as the clear, the flag stays set.
- R6: Address 4 holds the 3-bit priority. If at least one flag whose selector is non-zero is set and the priority is non-zero, `irq_req` is 1 and `irq_level` equals the priority. A priority of 0 forces `irq_req` and `irq_level` to 0.
- R7: Address 5 holds the 8-bit vector. When `iack` is 1, `iack_level` equals the priority and a request is active, `vec_valid` is 1 and `vec_out` shows the vector. In every other case both outputs are 0.
- R8: `arb_lowest` is always 1.
- R9: Setting a pin's selector to 00 masks that pin's flag from the request, but the flag stays readable at address 3.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Per-pin output enable |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Requested priority |
| iack | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Priority being acknowledged |
| vec_valid | output | 1 | Vector is being supplied |
| vec_out | output | 8 | Supplied vector |
| arb_lowest | output | 1 | Lowest arbitration rank marker |

## Verification
Four things are checked on every cycle by the assertions:
- a flag never rises without a transition detected one cycle earlier;
- a write-1 clear leaves a flag set only when a new transition arrived in the same cycle;
- the latch reaches `pin_out` one cycle after a write;
- a zero priority silences the request, and the vector is only offered during a matching, active acknowledge.

Other behaviours can only be shown by the bench scenarios:
- the exact three-edge detection latency;
- the mixed read-back of address 0;
- the meaning of each selector code;
- masking through the selector;
- that writes to unmapped addresses are ignored.

// File: rtl/edgeirq_pkg.sv
`timescale 1ns/1ps
package edgeirq_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } sel_code_e;

  localparam logic [2:0] A_LATCH = 3'd0;
  localparam logic [2:0] A_DIR   = 3'd1;
  localparam logic [2:0] A_SEL   = 3'd2;
  localparam logic [2:0] A_FLAG  = 3'd3;
  localparam logic [2:0] A_PRIO  = 3'd4;
  localparam logic [2:0] A_VECT  = 3'd5;

  // Transition test for one pin: bit 0 of the code watches rising, bit 1 falling.
  function automatic logic pin_edge(input logic [1:0] code, input logic now_v, input logic old_v);
    return (code[0] & now_v & ~old_v) | (code[1] & ~now_v & old_v);
  endfunction

endpackage

// File: rtl/edgeirq_sync.sv
`timescale 1ns/1ps
module edgeirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/edgeirq_detect.sv
`timescale 1ns/1ps
module edgeirq_detect
  import edgeirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cur,
  input  logic [2*W-1:0] sel,
  input  logic [W-1:0]   clr,
  output logic [W-1:0]   hits,
  output logic [W-1:0]   flags
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hits[i] = pin_edge(sel[2*i +: 2], cur[i], prev_q[i]);
  end

  // A new transition wins over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hits;
  end

  // R4: a flag only rises after a detected transition in the previous cycle.
  assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(hits)) == '0));

  // R5: after a clear, only bits that saw a new transition may remain set.
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((flags & $past(clr) & ~$past(hits)) == '0));
endmodule

// File: rtl/edgeirq_port.sv
`timescale 1ns/1ps
module edgeirq_port
  import edgeirq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int LVL_W       = 3,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_addr,
  input  logic [2*WIDTH-1:0]   bus_wdata,
  output logic [2*WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]     pin_in,
  output logic [WIDTH-1:0]     pin_out,
  output logic [WIDTH-1:0]     pin_oe,
  output logic                 irq_req,
  output logic [LVL_W-1:0]     irq_level,
  input  logic                 iack,
  input  logic [LVL_W-1:0]     iack_level,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 arb_lowest
);
  localparam int REG_W = 2 * WIDTH;

  logic [WIDTH-1:0] latch_q, dir_q;
  logic [REG_W-1:0] sel_q;
  logic [LVL_W-1:0] prio_q;
  logic [VEC_W-1:0] vect_q;

  logic wr_latch, wr_dir, wr_sel, wr_flag, wr_prio, wr_vect;
  logic [WIDTH-1:0] pin_sync, hits, flags, watch_en, discrete, flag_clr;
  logic pending;

  // Mixed read-back: synchronized pin for discrete inputs, latch otherwise.
  function automatic logic [WIDTH-1:0] mix_read(input logic [WIDTH-1:0] lat,
                                                input logic [WIDTH-1:0] pin,
                                                input logic [WIDTH-1:0] use_pin);
    return (pin & use_pin) | (lat & ~use_pin);
  endfunction

  always_comb begin
    wr_latch = bus_wr && (bus_addr == A_LATCH);
    wr_dir   = bus_wr && (bus_addr == A_DIR);
    wr_sel   = bus_wr && (bus_addr == A_SEL);
    wr_flag  = bus_wr && (bus_addr == A_FLAG);
    wr_prio  = bus_wr && (bus_addr == A_PRIO);
    wr_vect  = bus_wr && (bus_addr == A_VECT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      sel_q   <= '0;
      prio_q  <= '0;
      vect_q  <= '0;
    end else begin
      if (wr_latch) latch_q <= bus_wdata[WIDTH-1:0];
      if (wr_dir)   dir_q   <= bus_wdata[WIDTH-1:0];
      if (wr_sel)   sel_q   <= bus_wdata;
      if (wr_prio)  prio_q  <= bus_wdata[LVL_W-1:0];
      if (wr_vect)  vect_q  <= bus_wdata[VEC_W-1:0];
    end
  end

  assign flag_clr = wr_flag ? bus_wdata[WIDTH-1:0] : '0;

  edgeirq_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  edgeirq_detect #(.W(WIDTH)) u_detect (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (pin_sync),
    .sel  (sel_q),
    .clr  (flag_clr),
    .hits (hits),
    .flags(flags)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_en
    assign watch_en[i] = (sel_q[2*i +: 2] != SEL_OFF);
  end

  assign discrete   = ~dir_q & ~watch_en;
  assign pending    = |(flags & watch_en);
  assign irq_req    = pending && (prio_q != '0);
  assign irq_level  = irq_req ? prio_q : '0;
  assign vec_valid  = iack && irq_req && (iack_level == prio_q);
  assign vec_out    = vec_valid ? vect_q : '0;
  assign arb_lowest = 1'b1;
  assign pin_out    = latch_q;
  assign pin_oe     = dir_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LATCH: bus_rdata[WIDTH-1:0] = mix_read(latch_q, pin_sync, discrete);
      A_DIR:   bus_rdata[WIDTH-1:0] = dir_q;
      A_SEL:   bus_rdata            = sel_q;
      A_FLAG:  bus_rdata[WIDTH-1:0] = flags;
      A_PRIO:  bus_rdata[LVL_W-1:0] = prio_q;
      A_VECT:  bus_rdata[VEC_W-1:0] = vect_q;
      default: bus_rdata            = '0;
    endcase
  end

  // R2: the written latch value appears on the pins one cycle later.
  assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> (pin_out == $past(bus_wdata[WIDTH-1:0])));

  // R6: a zero priority keeps the request silent.
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q == '0) |-> (!irq_req && irq_level == '0));

  // R7: the vector is only offered during a matching, active acknowledge.
  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (iack && irq_req && iack_level == irq_level && vec_out == vect_q));
endmodule

// File: tb/sim_edgeirq_port.sv
`timescale 1ns/1ps
module sim_edgeirq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic        iack = 1'b0;
  logic [2:0]  iack_level = '0;
  logic        vec_valid;
  logic [7:0]  vec_out;
  logic        arb_lowest;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edgeirq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req), .irq_level(irq_level),
    .iack(iack), .iack_level(iack_level), .vec_valid(vec_valid), .vec_out(vec_out),
    .arb_lowest(arb_lowest)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1", $sformatf("reg %0d after reset", a), d, 16'h0);
    end
    check("R1", "pin_oe", {8'h0, pin_oe}, 16'h0);
    check("R1", "irq_req", {15'h0, irq_req}, 16'h0);
    check("R1", "irq_level", {13'h0, irq_level}, 16'h0);
    check("R8", "arb_lowest", {15'h0, arb_lowest}, 16'h1);
  endtask

  task automatic t_drive;
    wr(3'd1, 16'h00F0);
    wr(3'd0, 16'h00A5);
    check("R2", "pin_out", {8'h0, pin_out}, 16'h00A5);
    check("R2", "pin_oe", {8'h0, pin_oe}, 16'h00F0);
  endtask

  task automatic t_readback;
    logic [15:0] d;
    logic [7:0] disc;
    @(negedge clk); pin_in = 8'h3C;
    wr(3'd2, 16'h0001);
    settle(3);
    disc = ~8'hF0 & ~8'h01;
    rd(3'd0, d);
    check("R3", "mixed read", d, {8'h0, (8'h3C & disc) | (8'hA5 & ~disc)});
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    rd(3'd0, d);
    check("R3", "all discrete inputs", d, 16'h003C);
    rd(3'd3, d);
    check("R4", "no flags with selectors off", d, 16'h0);
  endtask

  task automatic t_edges;
    logic [15:0] d;
    @(negedge clk); pin_in = 8'h00;
    settle(4);
    wr(3'd4, 16'h0003);
    wr(3'd5, 16'h0042);
    wr(3'd2, 16'h0039); // pin0 rise, pin1 fall, pin2 both, pin3 off
    @(negedge clk); pin_in = 8'h0F;
    settle(2);
    rd(3'd3, d); // read happens on the following low phase: still two edges plus one
    @(negedge clk);
    bus_addr = 3'd3;
    #1 d = bus_rdata;
    check("R4", "rising flags after 3 edges", d, 16'h0005);
    check("R6", "irq_req", {15'h0, irq_req}, 16'h1);
    check("R6", "irq_level", {13'h0, irq_level}, 16'h3);
    wr(3'd3, 16'h0005);
    rd(3'd3, d);
    check("R5", "flags cleared", d, 16'h0);
    check("R6", "irq_req after clear", {15'h0, irq_req}, 16'h0);
    @(negedge clk); pin_in = 8'h00;
    settle(3);
    rd(3'd3, d);
    check("R4", "falling flags", d, 16'h0006);
  endtask

  task automatic t_latency;
    logic [15:0] d;
    // pin2 rises; flag must still be clear after two edges, set after the third.
    wr(3'd3, 16'h00FF);
    @(negedge clk); pin_in = 8'h04;
    repeat (2) @(posedge clk);
    @(negedge clk); bus_addr = 3'd3;
    #1 d = bus_rdata;
    check("R4", "flag not set after 2 edges", d, 16'h0);
    @(posedge clk);
    @(negedge clk);
    #1 d = bus_rdata;
    check("R4", "flag set after 3 edges", d, 16'h0004);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    @(negedge clk); pin_in = 8'h00;
    settle(3);
    rd(3'd3, d);
    check("R4", "both-edge falling flag", d, 16'h0004);
    @(negedge clk); pin_in = 8'h02;
    settle(3);
    @(negedge clk); pin_in = 8'h00;
    settle(3);
    rd(3'd3, d);
    check("R4", "pin1 falling plus pin2", d, 16'h0006);
    wr(3'd3, 16'h0002);
    rd(3'd3, d);
    check("R5", "partial clear", d, 16'h0004);
    // New transition on pin2 lands in the same cycle as its clear.
    @(negedge clk); pin_in = 8'h04;
    @(posedge clk);
    @(posedge clk);
    wr(3'd3, 16'h0004);
    rd(3'd3, d);
    check("R5", "set wins over clear", d, 16'h0004);
    wr(3'd3, 16'h0004);
    rd(3'd3, d);
    check("R5", "clear afterwards", d, 16'h0);
  endtask

  task automatic t_mask;
    @(negedge clk); pin_in = 8'h00;
    settle(3);
    check("R6", "request with flag", {15'h0, irq_req}, 16'h1);
    wr(3'd4, 16'h0000);
    check("R6", "zero priority masks req", {15'h0, irq_req}, 16'h0);
    check("R6", "zero priority level", {13'h0, irq_level}, 16'h0);
    wr(3'd4, 16'h0003);
    check("R6", "request restored", {15'h0, irq_req}, 16'h1);
  endtask

  task automatic t_iack;
    @(negedge clk); iack = 1'b1; iack_level = 3'd3;
    #1;
    check("R7", "vec_valid matching", {15'h0, vec_valid}, 16'h1);
    check("R7", "vec_out matching", {8'h0, vec_out}, 16'h0042);
    @(negedge clk); iack_level = 3'd2;
    #1;
    check("R7", "vec_valid other level", {15'h0, vec_valid}, 16'h0);
    check("R7", "vec_out other level", {8'h0, vec_out}, 16'h0);
    @(negedge clk); iack = 1'b0;
  endtask

  task automatic t_select_mask;
    logic [15:0] d;
    wr(3'd2, 16'h0009); // pin2 off
    check("R9", "masked by selector", {15'h0, irq_req}, 16'h0);
    rd(3'd3, d);
    check("R9", "flag still readable", d, 16'h0004);
    @(negedge clk); iack = 1'b1; iack_level = 3'd3;
    #1;
    check("R7", "no vector without request", {15'h0, vec_valid}, 16'h0);
    @(negedge clk); iack = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd6, d); check("R10", "addr 6 reads 0", d, 16'h0);
    rd(3'd7, d); check("R10", "addr 7 reads 0", d, 16'h0);
    rd(3'd4, d); check("R10", "priority unchanged", d, 16'h0003);
    rd(3'd5, d); check("R10", "vector unchanged", d, 16'h0042);
    rd(3'd1, d); check("R10", "direction unchanged", d, 16'h0);
    rd(3'd2, d); check("R10", "selectors unchanged", d, 16'h0009);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_drive;
    t_readback;
    t_edges;
    t_latency;
    t_w1c;
    t_mask;
    t_iack;
    t_select_mask;
    t_unmapped;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule